// File: doc/BRIEF.md
# Periodic Impedance Calibration Controller

This block is the digital loop that keeps the output-driver and input-termination impedance of a memory device matched while supply voltage and temperature drift. A free-running cycle counter raises an evaluation request at a fixed interval. An external sense circuit answers each request with a one-bit direction result and a valid strobe. The block then moves a binary-weighted impedance code by one step, up or down, and never past either end of its range.

The same calibration result feeds two codes: one for the output driver and one for the input termination. Both are registered from the same next value, so they change in the same cycle. A termination request pin (low by default) turns the termination on or off for three input groups: data, byte-write and clock. Small steps let the code follow slow drift without large jumps that would disturb the pads.

Top module: `imp_cal_ctrl`

## Requirements
- R1: `eval_req` is high for exactly one cycle every PERIOD clock cycles. The first pulse comes PERIOD cycles after reset is released.
- R2: While reset is active and right after it is released, `drv_code` and `term_code` both equal mid-scale (2^(CODE_W-1)), `eval_req` is 0 and `term_en` is 0.
- R3: A `cmp_valid` strobe that is accepted changes `drv_code` at the next clock edge. The code rises by one when `cmp_up` is 1 and falls by one when `cmp_up` is 0.
- R4: A `cmp_valid` strobe is accepted only while an evaluation is pending. An evaluation becomes pending in the cycle after an `eval_req` pulse and stops being pending when a strobe is accepted. A strobe outside that window leaves the code unchanged, and so does a second strobe in the same window.
- R5: The code saturates and never wraps. A step up at all-ones and a step down at all-zeros both leave the code where it is.
- R6: `term_code` equals `drv_code` in every cycle.
- R7: Each bit of `term_en` equals the value `odt_req` had one cycle earlier. Bit 0 is data, bit 1 is byte-write and bit 2 is clock.
- R8: In a cycle without `cmp_valid`, `drv_code` keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| odt_req | input | 1 | Termination request. 1 enables termination; it defaults to 0 |
| cmp_valid | input | 1 | Valid strobe for the sense result |
| cmp_up | input | 1 | Sense result: 1 steps the code up, 0 steps it down |
| eval_req | output | 1 | One-cycle pulse that asks for an evaluation |
| drv_code | output | CODE_W | Output-driver impedance code |
| term_code | output | CODE_W | Input-termination impedance code |
| term_en | output | 3 | Termination enables for the data, byte-write and clock groups |

## Verification
The assertions assume that `cmp_valid` is a clean synchronous strobe. They also assume that `cmp_up` and `odt_req` carry known values from reset onward, and that the sense circuit answers no earlier than the cycle after a request. The stimulus drives every input at the falling edge. It holds `odt_req`, `cmp_valid` and `cmp_up` low through reset. It raises `cmp_valid` for exactly one cycle at a time, once at the earliest point after a request and once deliberately outside any pending window. Because the steps are always one cycle long, each expected code step lines up with a single rising edge.

// File: rtl/imp_cal_pkg.sv
package imp_cal_pkg;
   localparam int TG_DATA     = 0;
   localparam int TG_BWRITE   = 1;
   localparam int TG_CLOCK    = 2;
   localparam int TERM_GROUPS = 3;

   typedef enum logic [1:0] {
      STEP_HOLD = 2'd0,
      STEP_UP   = 2'd1,
      STEP_DOWN = 2'd2
   } step_e;
endpackage

// File: rtl/cal_tick_gen.sv
module cal_tick_gen #(
   parameter int PERIOD = 1024
) (
   input  logic clk,
   input  logic rst_n,
   output logic tick
);
   localparam int CNT_W = (PERIOD > 2) ? $clog2(PERIOD) : 1;
   localparam logic [CNT_W-1:0] LAST = CNT_W'(PERIOD - 1);

   if (PERIOD < 2) begin : g_bad_period
      $error("cal_tick_gen: PERIOD must be at least 2");
   end

   logic [CNT_W-1:0] cnt_q;
   logic             wrap;

   assign wrap = (cnt_q == LAST);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
         tick  <= 1'b0;
      end else begin
         cnt_q <= wrap ? '0 : cnt_q + 1'b1;
         tick  <= wrap;
      end
   end
endmodule

// File: rtl/cal_handshake.sv
module cal_handshake
   import imp_cal_pkg::*;
(
   input  logic  clk,
   input  logic  rst_n,
   input  logic  eval_req,
   input  logic  cmp_valid,
   input  logic  cmp_up,
   output step_e step
);
   logic pending_q;
   logic accept;

   assign accept = cmp_valid && pending_q;

   always_comb begin
      step = STEP_HOLD;
      if (accept) begin
         step = cmp_up ? STEP_UP : STEP_DOWN;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pending_q <= 1'b0;
      end else if (eval_req) begin
         pending_q <= 1'b1;
      end else if (accept) begin
         pending_q <= 1'b0;
      end
   end
endmodule

// File: rtl/cal_code_reg.sv
module cal_code_reg
   import imp_cal_pkg::*;
#(
   parameter int CODE_W = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  step_e             step,
   output logic [CODE_W-1:0] drv_q,
   output logic [CODE_W-1:0] trm_q
);
   localparam logic [CODE_W-1:0] MID  = CODE_W'(1) << (CODE_W - 1);
   localparam logic [CODE_W-1:0] CMAX = {CODE_W{1'b1}};
   localparam logic [CODE_W-1:0] CMIN = {CODE_W{1'b0}};

   if (CODE_W < 2) begin : g_bad_width
      $error("cal_code_reg: CODE_W must be at least 2");
   end

   logic [CODE_W-1:0] nxt;

   always_comb begin
      nxt = drv_q;
      case (step)
         STEP_UP:   if (drv_q != CMAX) nxt = drv_q + 1'b1;
         STEP_DOWN: if (drv_q != CMIN) nxt = drv_q - 1'b1;
         default:   nxt = drv_q;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         drv_q <= MID;
         trm_q <= MID;
      end else begin
         drv_q <= nxt;
         trm_q <= nxt;
      end
   end
endmodule

// File: rtl/cal_term_gate.sv
module cal_term_gate
   import imp_cal_pkg::*;
#(
   parameter bit REG_EN = 1'b1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   odt_req,
   output logic [TERM_GROUPS-1:0] term_en
);
   if (REG_EN) begin : g_reg
      always_ff @(posedge clk) begin
         if (!rst_n) term_en <= '0;
         else        term_en <= {TERM_GROUPS{odt_req}};
      end
   end else begin : g_comb
      assign term_en = rst_n ? {TERM_GROUPS{odt_req}} : '0;
   end
endmodule

// File: rtl/imp_cal_ctrl.sv
module imp_cal_ctrl
   import imp_cal_pkg::*;
#(
   parameter int PERIOD = 1024,
   parameter int CODE_W = 6,
   parameter bit REG_EN = 1'b1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   odt_req,
   input  logic                   cmp_valid,
   input  logic                   cmp_up,
   output logic                   eval_req,
   output logic [CODE_W-1:0]      drv_code,
   output logic [CODE_W-1:0]      term_code,
   output logic [TERM_GROUPS-1:0] term_en
);
   step_e step;

   cal_tick_gen #(.PERIOD(PERIOD)) u_tick (
      .clk   (clk),
      .rst_n (rst_n),
      .tick  (eval_req)
   );

   cal_handshake u_hs (
      .clk       (clk),
      .rst_n     (rst_n),
      .eval_req  (eval_req),
      .cmp_valid (cmp_valid),
      .cmp_up    (cmp_up),
      .step      (step)
   );

   cal_code_reg #(.CODE_W(CODE_W)) u_code (
      .clk   (clk),
      .rst_n (rst_n),
      .step  (step),
      .drv_q (drv_code),
      .trm_q (term_code)
   );

   cal_term_gate #(.REG_EN(REG_EN)) u_term (
      .clk     (clk),
      .rst_n   (rst_n),
      .odt_req (odt_req),
      .term_en (term_en)
   );
endmodule

// File: rtl/imp_cal_chk.sv
module imp_cal_chk
   import imp_cal_pkg::*;
#(
   parameter int PERIOD = 1024,
   parameter int CODE_W = 6,
   parameter bit REG_EN = 1'b1
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic                   odt_req,
   input logic                   cmp_valid,
   input logic                   cmp_up,
   input logic                   eval_req,
   input logic [CODE_W-1:0]      drv_code,
   input logic [CODE_W-1:0]      term_code,
   input logic [TERM_GROUPS-1:0] term_en
);
   localparam int GAP_W = $clog2(PERIOD + 1);
   localparam logic [GAP_W-1:0] GAP_FULL = GAP_W'(PERIOD);

   logic [GAP_W-1:0] gap_q;
   logic             past_ok;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         gap_q   <= '0;
         past_ok <= 1'b0;
      end else begin
         past_ok <= 1'b1;
         if (eval_req)              gap_q <= GAP_W'(1);
         else if (gap_q != GAP_FULL) gap_q <= gap_q + 1'b1;
      end
   end

   // R1
   a_r1_req_on_time: assert property (@(posedge clk) disable iff (!rst_n)
      eval_req |-> gap_q == GAP_FULL);
   a_r1_req_not_late: assert property (@(posedge clk) disable iff (!rst_n)
      gap_q == GAP_FULL |-> eval_req);
   // R3
   a_r3_single_step: assert property (@(posedge clk) disable iff (!rst_n)
      past_ok && drv_code != $past(drv_code) |->
         ({1'b0, drv_code} == {1'b0, $past(drv_code)} + 1'b1) ||
         ({1'b0, drv_code} + 1'b1 == {1'b0, $past(drv_code)}));
   // R8
   a_r8_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
      past_ok && !$past(cmp_valid) |-> $stable(drv_code));
   // R5
   a_r5_no_wrap_top: assert property (@(posedge clk) disable iff (!rst_n)
      past_ok && $past(drv_code) == {CODE_W{1'b1}} |-> drv_code != '0);
   a_r5_no_wrap_bottom: assert property (@(posedge clk) disable iff (!rst_n)
      past_ok && $past(drv_code) == '0 |-> drv_code != {CODE_W{1'b1}});
   // R6
   a_r6_term_tracks: assert property (@(posedge clk) disable iff (!rst_n)
      term_code == drv_code);
   // R7
   if (REG_EN) begin : g_en_chk
      a_r7_term_enable: assert property (@(posedge clk) disable iff (!rst_n)
         past_ok |-> term_en == {TERM_GROUPS{$past(odt_req)}});
   end
endmodule

bind imp_cal_ctrl imp_cal_chk #(
   .PERIOD (PERIOD),
   .CODE_W (CODE_W),
   .REG_EN (REG_EN)
) u_chk (.*);

// File: tb/imp_cal_ctrl_tb.sv
module imp_cal_ctrl_tb;
   localparam int CLK_PERIOD = 10;
   localparam int PERIOD     = 32;
   localparam int CODE_W     = 4;
   localparam logic [CODE_W-1:0] MID = 4'd8;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              odt_req = 1'b0;
   logic              cmp_valid = 1'b0;
   logic              cmp_up = 1'b0;
   logic              eval_req;
   logic [CODE_W-1:0] drv_code;
   logic [CODE_W-1:0] term_code;
   logic [2:0]        term_en;

   int n_chk = 0;
   int n_fail = 0;
   int exp_code = 8;
   logic [CODE_W-1:0] exp_q[$];
   string             tag_q[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   imp_cal_ctrl #(.PERIOD(PERIOD), .CODE_W(CODE_W)) u_dut (
      .clk(clk), .rst_n(rst_n), .odt_req(odt_req), .cmp_valid(cmp_valid),
      .cmp_up(cmp_up), .eval_req(eval_req), .drv_code(drv_code),
      .term_code(term_code), .term_en(term_en));

   task automatic check(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // monitor: pops an expected code after each rising edge following a strobe
   initial begin
      forever begin
         @(posedge clk);
         #1;
         if (exp_q.size() > 0) begin
            automatic logic [CODE_W-1:0] e = exp_q.pop_front();
            automatic string t = tag_q.pop_front();
            check(t, drv_code, e);
            check("R6 term_code", term_code, e);
         end
      end
   end

   task automatic wait_req();
      while (eval_req !== 1'b1) @(negedge clk);
   endtask

   // driver: one strobe, expected value pushed to the scoreboard
   task automatic strobe(input logic up, input bit accepted, input string t);
      cmp_valid = 1'b1;
      cmp_up    = up;
      if (accepted) begin
         if (up && exp_code < 15) exp_code++;
         else if (!up && exp_code > 0) exp_code--;
      end
      exp_q.push_back(CODE_W'(exp_code));
      tag_q.push_back(t);
      @(negedge clk);
      cmp_valid = 1'b0;
   endtask

   task automatic eval_step(input logic up, input string t);
      wait_req();
      @(negedge clk);
      strobe(up, 1'b1, t);
   endtask

   initial begin
      fork
         begin
            repeat (4) @(negedge clk);
            check("R2 reset drv_code", drv_code, MID);
            check("R2 reset term_code", term_code, MID);
            check("R2 reset eval_req", eval_req, 0);
            check("R2 reset term_en", term_en, 0);
            rst_n = 1'b1;
            @(negedge clk);
            check("R2 post-reset code", drv_code, MID);
            // R4: strobe before any request is ignored
            strobe(1'b1, 1'b0, "R4 strobe before request");
            @(negedge clk);
            // R1: interval between pulses
            wait_req();
            @(negedge clk);
            check("R1 pulse width", eval_req, 0);
            begin
               automatic int n = 1;
               while (eval_req !== 1'b1) begin @(negedge clk); n++; end
               check("R1 period", n, PERIOD);
            end
            // R3: one step up, then a second strobe in the same window is ignored (R4)
            @(negedge clk);
            strobe(1'b1, 1'b1, "R3 step up");
            strobe(1'b1, 1'b0, "R4 second strobe same window");
            // R8: no strobe across a full period keeps the code
            repeat (PERIOD + 3) @(negedge clk);
            check("R8 hold without strobe", drv_code, 9);
            eval_step(1'b0, "R3 step down");
            // R5: saturate at top
            for (int i = 0; i < 9; i++) eval_step(1'b1, "R5 climb to top");
            @(negedge clk);
            check("R5 top saturation", drv_code, 15);
            // R5: saturate at bottom
            for (int i = 0; i < 17; i++) eval_step(1'b0, "R5 descend to bottom");
            @(negedge clk);
            check("R5 bottom saturation", drv_code, 0);
            // R7: termination enable follows odt_req one cycle later
            odt_req = 1'b1;
            #1;
            check("R7 enable not yet", term_en, 0);
            @(negedge clk);
            check("R7 enable all groups", term_en, 7);
            odt_req = 1'b0;
            @(negedge clk);
            check("R7 disable all groups", term_en, 0);
            repeat (3) @(negedge clk);
         end
         begin
            repeat (20000) @(negedge clk);
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=done");
         end
      join_any
      disable fork;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule